// File: doc/BRIEF.md
# Bit-Plane Mask and Blink Colour-Source Selector

This block sits at the front of a palette lookup pipeline and decides where each pixel's colour comes from. Every load cycle brings an 8-bit palette index, a 2-bit overlay code, a blank flag and a sync flag. The index passes through a read mask. In the off half of the blink cycle it also passes through a blink mask. The overlay bits are gated on their own by a display enable and a blink enable for each bit. The result is a choice between the 256-entry palette and one of four overlay registers. That choice, its address and the delayed sync and blank flags leave on one registered output stage.

Blink timing is counted in vertical periods, not in clock cycles. The block treats a long unbroken run of blank-low cycles as a vertical retrace. Each retrace advances a frame counter, and the counter flips the blink phase when the current half of the cycle has used up its frame count. Because of this, the phase can only change while the screen is blanked. The register values that steer the block are inputs: the mask values, the RAM-enable bit, the overlay enable bits and the blink-rate code. The palette storage and the converters are outside this block.

Top module: `plane_mask_blink_sel`

## Requirements
- R1: When the palette is selected, `out_addr` equals the input index ANDed bitwise with `rd_mask`.
- R2: In the off phase, every index bit whose `bl_mask` bit is 1 is cleared, and index bits whose `bl_mask` bit is 0 pass unchanged. In the on phase, `bl_mask` has no effect.
- R3: A retrace is counted once the blank input has been low for 256 consecutive cycles. A blank run counts as at most one retrace until blank returns high. The blink phase changes only at a retrace.
- R4: The blink-rate code gives on/off lengths in retraces. Code 00 gives 16 on / 48 off, 01 gives 16/16, 10 gives 32/32, and 11 behaves like 01. Each cycle starts in the on phase.
- R5: An overlay code bit whose display-enable bit (`ovl_disp_en`, bit i for code bit i) is 0 is treated as 0.
- R6: An overlay code bit whose blink-enable bit (`ovl_blink_en`, bit i) is 1 is treated as 0 during the off phase.
- R7: Let the gated overlay code be the code after R5 and R6. `out_pal_sel`=1 only when `ram_en`=1 and the gated code is 0, and `out_ovl` is then 0. Otherwise `out_pal_sel`=0, `out_addr`=0, and `out_ovl` equals the gated code, which selects overlay register 0 when `ram_en`=0 and the code is 0.
- R8: When `blank_n` is low, the index and overlay inputs are ignored. The next output has `out_blank_n`=0, `out_pal_sel`=0, `out_addr`=0 and `out_ovl`=0.
- R9: All outputs are registered one clock after the inputs that produce them, and `out_sync_n` and `out_blank_n` carry `sync_n` and `blank_n` with that same one-cycle delay.
- R10: Synchronous reset (`rst`=1) puts the phase on, clears the frame count, re-arms retrace detection, and drives all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel/load clock, one pixel per cycle |
| rst | input | 1 | Synchronous reset, active high |
| pix_idx | input | 8 | Palette index for this pixel |
| ovl_code | input | 2 | Overlay code for this pixel |
| blank_n | input | 1 | Blank flag, low blanks the pixel |
| sync_n | input | 1 | Sync flag, passed through delayed |
| rd_mask | input | 8 | Read-mask register value |
| bl_mask | input | 8 | Blink-mask register value |
| ram_en | input | 1 | Allows palette selection for overlay code 0 |
| ovl_disp_en | input | 2 | Display enable for each overlay bit |
| ovl_blink_en | input | 2 | Blink enable for each overlay bit |
| blink_rate | input | 2 | Blink-rate code |
| out_pal_sel | output | 1 | 1 = palette is the colour source |
| out_addr | output | 8 | Palette address |
| out_ovl | output | 2 | Overlay register number |
| out_sync_n | output | 1 | Delayed sync flag |
| out_blank_n | output | 1 | Delayed blank flag |

## Verification
The retrace event and blank forcing fall in the same cycle. The 256th consecutive blank-low sample both flips the blink phase and is itself forced to the blank level. The pixel right after it must be gated with the new phase. The bench provokes this with frames whose blank runs sit just below, at and far above the threshold. It compares each output on every clock against a behavioural model that counts runs and frames with plain integers. It also counts off-phase frames over 64 frames for each rate code.

// File: rtl/plane_mask_blink_sel_pkg.sv
package plane_mask_blink_sel_pkg;

   typedef enum logic [1:0] {
      RATE_ONE_THREE = 2'b00,
      RATE_ONE_ONE   = 2'b01,
      RATE_TWO_TWO   = 2'b10,
      RATE_ALIAS     = 2'b11
   } blink_rate_e;

   // on-phase length in blink units
   function automatic int unsigned on_units(blink_rate_e r);
      case (r)
         RATE_TWO_TWO: on_units = 2;
         default:      on_units = 1;
      endcase
   endfunction

   // off-phase length in blink units
   function automatic int unsigned off_units(blink_rate_e r);
      case (r)
         RATE_ONE_THREE: off_units = 3;
         RATE_TWO_TWO:   off_units = 2;
         default:        off_units = 1;
      endcase
   endfunction

endpackage

// File: rtl/plane_mask_blink_sel_retrace.sv
module plane_mask_blink_sel_retrace #(
   parameter int RUN_LEN = 256
) (
   input  logic clk,
   input  logic rst,
   input  logic blank_n,
   output logic retrace
);
   localparam int CW = (RUN_LEN > 2) ? $clog2(RUN_LEN) : 1;
   localparam logic [CW-1:0] LAST = CW'(RUN_LEN - 1);

   logic [CW-1:0] run_cnt;
   logic          armed;

   // fires on the RUN_LEN-th consecutive low sample, once per run
   assign retrace = !blank_n && armed && (run_cnt == LAST);

   always_ff @(posedge clk) begin
      if (rst) begin
         run_cnt <= '0;
         armed   <= 1'b1;
      end else if (blank_n) begin
         run_cnt <= '0;
         armed   <= 1'b1;
      end else if (armed) begin
         if (run_cnt == LAST) begin
            armed <= 1'b0;
         end else begin
            run_cnt <= run_cnt + CW'(1);
         end
      end
   end
endmodule

// File: rtl/plane_mask_blink_sel_blink.sv
module plane_mask_blink_sel_blink #(
   parameter int BLINK_UNIT = 16
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       tick,
   input  logic [1:0] rate,
   output logic       blink_off
);
   import plane_mask_blink_sel_pkg::*;

   localparam int MAX_SPAN = 3 * BLINK_UNIT;
   localparam int CW       = $clog2(MAX_SPAN + 1);

   blink_rate_e   rate_e;
   logic [CW-1:0] span;
   logic [CW-1:0] frame_cnt;

   always_comb begin
      rate_e = blink_rate_e'(rate);
      if (blink_off) span = CW'(off_units(rate_e) * BLINK_UNIT);
      else           span = CW'(on_units(rate_e) * BLINK_UNIT);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         frame_cnt <= '0;
         blink_off <= 1'b0;
      end else if (tick) begin
         // >= so a rate change mid-phase cannot strand the counter
         if (frame_cnt >= span - CW'(1)) begin
            frame_cnt <= '0;
            blink_off <= !blink_off;
         end else begin
            frame_cnt <= frame_cnt + CW'(1);
         end
      end
   end
endmodule

// File: rtl/plane_mask_blink_sel_gate.sv
module plane_mask_blink_sel_gate #(
   parameter int IDX_W = 8,
   parameter int OVL_W = 2
) (
   input  logic [IDX_W-1:0] pix_idx,
   input  logic [OVL_W-1:0] ovl_code,
   input  logic [IDX_W-1:0] rd_mask,
   input  logic [IDX_W-1:0] bl_mask,
   input  logic             blink_off,
   input  logic             ram_en,
   input  logic [OVL_W-1:0] ovl_disp_en,
   input  logic [OVL_W-1:0] ovl_blink_en,
   output logic             use_pal,
   output logic [IDX_W-1:0] sel_addr,
   output logic [OVL_W-1:0] sel_ovl
);
   logic [IDX_W-1:0] idx_masked;
   logic [OVL_W-1:0] code_eff;

   assign idx_masked = pix_idx & rd_mask & ~(blink_off ? bl_mask : '0);

   for (genvar g = 0; g < OVL_W; g++) begin : g_ovl_plane
      assign code_eff[g] = ovl_code[g] & ovl_disp_en[g] & ~(ovl_blink_en[g] & blink_off);
   end

   assign use_pal  = ram_en && (code_eff == '0);
   assign sel_addr = use_pal ? idx_masked : '0;
   assign sel_ovl  = use_pal ? '0 : code_eff;
endmodule

// File: rtl/plane_mask_blink_sel.sv
module plane_mask_blink_sel #(
   parameter int IDX_W       = 8,
   parameter int OVL_W       = 2,
   parameter int RETRACE_LEN = 256,
   parameter int BLINK_UNIT  = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [IDX_W-1:0] pix_idx,
   input  logic [OVL_W-1:0] ovl_code,
   input  logic             blank_n,
   input  logic             sync_n,
   input  logic [IDX_W-1:0] rd_mask,
   input  logic [IDX_W-1:0] bl_mask,
   input  logic             ram_en,
   input  logic [OVL_W-1:0] ovl_disp_en,
   input  logic [OVL_W-1:0] ovl_blink_en,
   input  logic [1:0]       blink_rate,
   output logic             out_pal_sel,
   output logic [IDX_W-1:0] out_addr,
   output logic [OVL_W-1:0] out_ovl,
   output logic             out_sync_n,
   output logic             out_blank_n
);
   initial begin
      assert (IDX_W >= 1) else $fatal(1, "IDX_W must be positive");
      assert (OVL_W >= 1) else $fatal(1, "OVL_W must be positive");
      assert (RETRACE_LEN >= 2) else $fatal(1, "RETRACE_LEN must be at least 2");
      assert (BLINK_UNIT >= 1) else $fatal(1, "BLINK_UNIT must be positive");
   end

   logic             retrace_tick;
   logic             blink_off;
   logic             use_pal;
   logic [IDX_W-1:0] sel_addr;
   logic [OVL_W-1:0] sel_ovl;

   plane_mask_blink_sel_retrace #(.RUN_LEN(RETRACE_LEN)) u_retrace (
      .clk     (clk),
      .rst     (rst),
      .blank_n (blank_n),
      .retrace (retrace_tick)
   );

   plane_mask_blink_sel_blink #(.BLINK_UNIT(BLINK_UNIT)) u_blink (
      .clk       (clk),
      .rst       (rst),
      .tick      (retrace_tick),
      .rate      (blink_rate),
      .blink_off (blink_off)
   );

   plane_mask_blink_sel_gate #(.IDX_W(IDX_W), .OVL_W(OVL_W)) u_gate (
      .pix_idx      (pix_idx),
      .ovl_code     (ovl_code),
      .rd_mask      (rd_mask),
      .bl_mask      (bl_mask),
      .blink_off    (blink_off),
      .ram_en       (ram_en),
      .ovl_disp_en  (ovl_disp_en),
      .ovl_blink_en (ovl_blink_en),
      .use_pal      (use_pal),
      .sel_addr     (sel_addr),
      .sel_ovl      (sel_ovl)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         out_pal_sel <= 1'b0;
         out_addr    <= '0;
         out_ovl     <= '0;
         out_sync_n  <= 1'b0;
         out_blank_n <= 1'b0;
      end else begin
         out_sync_n  <= sync_n;
         out_blank_n <= blank_n;
         if (!blank_n) begin
            out_pal_sel <= 1'b0;
            out_addr    <= '0;
            out_ovl     <= '0;
         end else begin
            out_pal_sel <= use_pal;
            out_addr    <= sel_addr;
            out_ovl     <= sel_ovl;
         end
      end
   end
endmodule

// File: rtl/plane_mask_blink_sel_chk.sv
module plane_mask_blink_sel_chk #(
   parameter int IDX_W = 8,
   parameter int OVL_W = 2
) (
   input logic             clk,
   input logic             rst,
   input logic             blank_n,
   input logic             sync_n,
   input logic [IDX_W-1:0] rd_mask,
   input logic             blink_off,
   input logic             out_pal_sel,
   input logic [IDX_W-1:0] out_addr,
   input logic [OVL_W-1:0] out_ovl,
   input logic             out_sync_n,
   input logic             out_blank_n
);
   logic past_ok;
   always_ff @(posedge clk) begin
      if (rst) past_ok <= 1'b0;
      else     past_ok <= 1'b1;
   end

   a_r1_addr_in_mask: assert property (@(posedge clk) disable iff (rst)
      (past_ok && out_pal_sel) |-> ((out_addr & ~$past(rd_mask)) == '0));

   a_r3_phase_moves_in_blank: assert property (@(posedge clk) disable iff (rst)
      (past_ok && $past(blank_n)) |-> $stable(blink_off));

   a_r7_source_exclusive: assert property (@(posedge clk) disable iff (rst)
      out_pal_sel ? (out_ovl == '0) : (out_addr == '0));

   a_r8_blank_forces_level: assert property (@(posedge clk) disable iff (rst)
      (past_ok && !$past(blank_n)) |-> (!out_blank_n && !out_pal_sel && out_addr == '0 && out_ovl == '0));

   a_r9_sync_one_late: assert property (@(posedge clk) disable iff (rst)
      past_ok |-> (out_sync_n == $past(sync_n)));

   a_r10_reset_clears: assert property (@(posedge clk)
      rst |=> (!out_pal_sel && out_addr == '0 && out_ovl == '0 && !out_sync_n && !out_blank_n));
endmodule

bind plane_mask_blink_sel plane_mask_blink_sel_chk #(.IDX_W(IDX_W), .OVL_W(OVL_W)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .blank_n     (blank_n),
   .sync_n      (sync_n),
   .rd_mask     (rd_mask),
   .blink_off   (blink_off),
   .out_pal_sel (out_pal_sel),
   .out_addr    (out_addr),
   .out_ovl     (out_ovl),
   .out_sync_n  (out_sync_n),
   .out_blank_n (out_blank_n)
);

// File: tb/plane_mask_blink_sel_bench.sv
module plane_mask_blink_sel_bench;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [7:0] pix_idx = '0;
   logic [1:0] ovl_code = '0;
   logic       blank_n = 1'b0;
   logic       sync_n = 1'b0;
   logic [7:0] rd_mask = 8'hFF;
   logic [7:0] bl_mask = 8'h00;
   logic       ram_en = 1'b1;
   logic [1:0] ovl_disp_en = 2'b11;
   logic [1:0] ovl_blink_en = 2'b00;
   logic [1:0] blink_rate = 2'b01;
   logic       out_pal_sel;
   logic [7:0] out_addr;
   logic [1:0] out_ovl;
   logic       out_sync_n;
   logic       out_blank_n;

   always #5 clk = ~clk;

   plane_mask_blink_sel u_plane_mask_blink_sel (
      .clk(clk), .rst(rst), .pix_idx(pix_idx), .ovl_code(ovl_code),
      .blank_n(blank_n), .sync_n(sync_n), .rd_mask(rd_mask), .bl_mask(bl_mask),
      .ram_en(ram_en), .ovl_disp_en(ovl_disp_en), .ovl_blink_en(ovl_blink_en),
      .blink_rate(blink_rate), .out_pal_sel(out_pal_sel), .out_addr(out_addr),
      .out_ovl(out_ovl), .out_sync_n(out_sync_n), .out_blank_n(out_blank_n)
   );

   int    n_chk = 0;
   int    n_err = 0;
   string cur_req = "R10";
   bit    done = 0;

   // behavioural model state
   int m_run = 0;
   bit m_armed = 1;
   int m_frames = 0;
   bit m_off = 0;

   task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic int on_len(logic [1:0] r);
      return (r == 2'b10) ? 32 : 16;
   endfunction
   function automatic int off_len(logic [1:0] r);
      if (r == 2'b00) return 48;
      if (r == 2'b10) return 32;
      return 16;
   endfunction

   // one clock: inputs are already set; predict, clock, compare
   task automatic cyc();
      logic       e_pal, e_sync, e_blank;
      logic [7:0] e_addr;
      logic [1:0] e_ovl, code;
      logic [7:0] ix;
      e_pal = 0; e_addr = 0; e_ovl = 0; e_sync = 0; e_blank = 0;
      if (!rst) begin
         e_sync = sync_n;
         e_blank = blank_n;
         if (blank_n) begin
            ix = pix_idx & rd_mask;
            if (m_off) ix = ix & ~bl_mask;
            for (int b = 0; b < 2; b++)
               code[b] = ovl_code[b] && ovl_disp_en[b] && !(ovl_blink_en[b] && m_off);
            if (ram_en && code == 2'b00) begin
               e_pal = 1; e_addr = ix;
            end else begin
               e_ovl = code;
            end
         end
      end
      @(posedge clk);
      if (rst) begin
         m_run = 0; m_armed = 1; m_frames = 0; m_off = 0;
      end else if (blank_n) begin
         m_run = 0; m_armed = 1;
      end else if (m_armed) begin
         m_run++;
         if (m_run >= 256) begin
            m_armed = 0;
            m_frames++;
            if (m_frames >= (m_off ? off_len(blink_rate) : on_len(blink_rate))) begin
               m_frames = 0;
               m_off = !m_off;
            end
         end
      end
      @(negedge clk);
      check(cur_req, "pal_sel", out_pal_sel, e_pal);
      check(cur_req, "addr", out_addr, e_addr);
      check(cur_req, "ovl", out_ovl, e_ovl);
      check(cur_req, "sync_n", out_sync_n, e_sync);
      check(cur_req, "blank_n", out_blank_n, e_blank);
   endtask

   task automatic drive(logic [7:0] idx, logic [1:0] oc, logic bn, logic sn);
      pix_idx = idx; ovl_code = oc; blank_n = bn; sync_n = sn;
      cyc();
   endtask

   task automatic do_reset();
      rst = 1;
      drive(8'h00, 2'b00, 1'b0, 1'b1);
      drive(8'h00, 2'b00, 1'b0, 1'b1);
      rst = 0;
   endtask

   // active pixels of idx, then a blank run; returns address of first pixel
   task automatic frame(int act, int blen, logic [7:0] idx, output logic [7:0] first);
      first = 0;
      for (int i = 0; i < act; i++) begin
         drive(idx, 2'b00, 1'b1, 1'b1);
         if (i == 0) first = out_addr;
      end
      for (int i = 0; i < blen; i++)
         drive(8'($urandom), 2'($urandom), 1'b0, (i > 8 && i < 40) ? 1'b0 : 1'b1);
   endtask

   initial begin
      logic [7:0] fa;
      int off_cnt, first_off;
      logic [7:0] exp_off[4];
      logic [7:0] exp_first[4];
      exp_off   = '{8'd48, 8'd32, 8'd32, 8'd32};
      exp_first = '{8'd16, 8'd16, 8'd32, 8'd16};

      // R10: reset state
      cur_req = "R10";
      drive(8'hAA, 2'b11, 1'b1, 1'b1);
      drive(8'hAA, 2'b11, 1'b1, 1'b1);
      check("R10", "reset blank_n", out_blank_n, 1'b0);
      rst = 0;

      // R1: read mask
      cur_req = "R1";
      rd_mask = 8'h5A; bl_mask = 8'h0F;
      for (int i = 0; i < 20; i++) drive(8'($urandom), 2'b00, 1'b1, 1'b1);
      drive(8'hFF, 2'b00, 1'b1, 1'b1);
      check("R1", "masked addr", out_addr, 8'h5A);

      // R7: source selection
      cur_req = "R7";
      for (int i = 0; i < 20; i++) drive(8'($urandom), 2'($urandom), 1'b1, 1'b1);
      ram_en = 0;
      drive(8'h33, 2'b00, 1'b1, 1'b1);
      check("R7", "ram off code0 ovl", {out_pal_sel, out_ovl}, 3'b000);
      ram_en = 1;
      drive(8'h33, 2'b10, 1'b1, 1'b1);
      check("R7", "code2 ovl", {out_pal_sel, out_ovl, out_addr}, {1'b0, 2'b10, 8'h00});

      // R8: blank forcing
      cur_req = "R8";
      for (int i = 0; i < 10; i++) drive(8'($urandom), 2'($urandom), 1'b0, 1'b1);
      drive(8'hFF, 2'b01, 1'b0, 1'b1);
      check("R8", "blanked", {out_blank_n, out_pal_sel, out_ovl, out_addr}, 12'h000);

      // R9: delayed sync and blank
      cur_req = "R9";
      drive(8'h11, 2'b00, 1'b0, 1'b0);
      check("R9", "sync delayed", out_sync_n, 1'b0);
      drive(8'h11, 2'b00, 1'b1, 1'b1);
      check("R9", "blank delayed", out_blank_n, 1'b1);

      // R3: threshold and single count per run
      cur_req = "R3";
      do_reset();
      rd_mask = 8'hFF; bl_mask = 8'hFF; blink_rate = 2'b01;
      frame(4, 255, 8'hFF, fa);
      for (int f = 0; f < 15; f++) frame(4, 256, 8'hFF, fa);
      drive(8'hFF, 2'b00, 1'b1, 1'b1);
      check("R3", "still on after 15 retraces", out_addr, 8'hFF);
      frame(4, 256, 8'hFF, fa);
      drive(8'hFF, 2'b00, 1'b1, 1'b1);
      check("R3", "off after 16th retrace", out_addr, 8'h00);

      // R2: blink mask in off phase
      cur_req = "R2";
      bl_mask = 8'h0F;
      drive(8'hF5, 2'b00, 1'b1, 1'b1);
      check("R2", "off phase masked", out_addr, 8'hF0);

      // R5 and R6: overlay gating in off phase
      cur_req = "R5";
      ovl_disp_en = 2'b01;
      drive(8'h00, 2'b11, 1'b1, 1'b1);
      check("R5", "disp enable", out_ovl, 2'b01);
      cur_req = "R6";
      ovl_disp_en = 2'b11; ovl_blink_en = 2'b01;
      drive(8'h00, 2'b11, 1'b1, 1'b1);
      check("R6", "blink enable", out_ovl, 2'b10);
      drive(8'hC3, 2'b01, 1'b1, 1'b1);
      check("R6", "blinked to palette", {out_pal_sel, out_addr}, {1'b1, 8'hC0});
      ovl_blink_en = 2'b00;

      // R3: a very long blank run counts once
      cur_req = "R3";
      do_reset();
      bl_mask = 8'hFF;
      frame(4, 5000, 8'hFF, fa);
      drive(8'hFF, 2'b00, 1'b1, 1'b1);
      check("R3", "long run single retrace", out_addr, 8'hFF);

      // R4: rates, counted over 64 frames each
      cur_req = "R4";
      for (int r = 0; r < 4; r++) begin
         blink_rate = 2'(r);
         do_reset();
         off_cnt = 0; first_off = -1;
         for (int f = 0; f < 64; f++) begin
            frame(4, 258, 8'hFF, fa);
            if (fa == 8'h00) begin
               off_cnt++;
               if (first_off < 0) first_off = f;
            end
         end
         check("R4", $sformatf("rate %0d off frames", r), off_cnt, exp_off[r]);
         check("R4", $sformatf("rate %0d first off", r), first_off, exp_first[r]);
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      #1500000;
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule